// File: doc/BRIEF.md
# Reset-Release Strap Sampler

This block sits between a processor's board-level control pins and its core. It watches an active-low processor reset pin together with an active-low init pin, an active-low flush pin, two local interrupt pins and two auxiliary strap pins. Every pin passes through a two-stage synchronizer into the `clk` domain.

The pins do one job at one moment and a different job the rest of the time. On the single cycle where the synchronized reset goes from active to inactive, the block latches the pins as configuration straps:
- the init pin requests built-in self test;
- the flush pin enables output floating for board test;
- the interrupt and auxiliary pins give a four-bit clock-ratio code.

The straps hold until reset is asserted again. While the core runs, a falling edge on the init pin gives a one-cycle soft-restart pulse. This restart leaves cache, floating-point and machine-check state alone. A falling edge on the flush pin starts a cache write-back-and-invalidate request, which stays pending until the flush engine returns a done indication.

The flush engine, the self-test logic and the clock multiplier sit outside this block. They consume its outputs.

Top module: `strap_sampler`

## Requirements
- R1: Each pin is passed through two synchronizer flops. A pin change driven before clock edge k shows at the registered outputs after edge k+2, so it is visible from the third rising edge on.
- R2: If `init_n` is low on the reset-release cycle, `bist_req` goes to 1 and stays at 1 until reset is asserted again.
- R3: If `flush_n` is low on the reset-release cycle, `pins_float` goes to 1 and stays at 1 until reset is asserted again.
- R4: On the reset-release cycle, `clk_ratio` captures the raw pin levels as {aux_strap[1], aux_strap[0], lint[1], lint[0]} (bit 3 down to bit 0). Later changes on those pins do not alter it until the next release.
- R5: While the core runs, a falling edge on the synchronized `init_n` gives `soft_init` high for exactly one cycle. A rising edge gives nothing.
- R6: While the core runs and no flush is pending, a falling edge on the synchronized `flush_n` gives a one-cycle `flush_start` pulse and sets `flush_pending`. `flush_pending` clears on the edge after `flush_done` is seen high. `flush_done` while nothing is pending has no effect.
- R7: A falling edge on `flush_n` while `flush_pending` is 1 is ignored: no `flush_start`, and no second request after the first completes.
- R8: `soft_init` and `flush_start` are never produced for pin edges seen while reset is active or in the reset-release cycle itself.
- R9: While the synchronized reset is active, `bist_req`, `pins_float`, `clk_ratio` and `flush_pending` are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| cpu_rst_n | input | 1 | Processor reset pin, active low, asynchronous |
| init_n | input | 1 | Init pin, active low, asynchronous |
| flush_n | input | 1 | Flush pin, active low, asynchronous |
| lint | input | 2 | Local interrupt pins, sampled as ratio straps |
| aux_strap | input | 2 | Auxiliary ratio strap pins |
| flush_done | input | 1 | Flush engine completion, synchronous to clk |
| soft_init | output | 1 | One-cycle soft restart pulse |
| flush_start | output | 1 | One-cycle flush launch pulse |
| flush_pending | output | 1 | Flush request outstanding |
| bist_req | output | 1 | Latched self-test request strap |
| pins_float | output | 1 | Latched board-test output-float strap |
| clk_ratio | output | 4 | Latched clock-ratio strap code |

## Verification
Release-edge detection must sample the pins exactly once. If it fires a cycle late or a cycle early, or if the previous-reset register is stale, the straps take the wrong values, or a release-cycle pin edge leaks out as a `soft_init` or `flush_start` pulse. Such a fault shows at the ports three cycles after the pin change. A corrupted flush state shows as a missing or extra `flush_start`, or as `flush_pending` that will not clear. Each of these is visible one cycle after the faulty transition. Strap registers that fail to hold show as a `clk_ratio` that follows the pins at run time, three cycles after those pins move.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int LINT_W      = 2;
    localparam int AUX_W       = 2;
    localparam int RATIO_W     = LINT_W + AUX_W;

    // Synchronized view of every sampled pin, in a fixed packed order
    typedef struct packed {
        logic              rst_n;
        logic              init_n;
        logic              flush_n;
        logic [LINT_W-1:0] lint;
        logic [AUX_W-1:0]  aux;
    } pin_bank_t;

    localparam int PIN_W = $bits(pin_bank_t);

    // Configuration captured on reset release
    typedef struct packed {
        logic               bist;
        logic               float_outs;
        logic [RATIO_W-1:0] ratio;
    } strap_t;

    localparam strap_t STRAP_CLEAR = '{bist: 1'b0, float_outs: 1'b0, ratio: '0};

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_BUSY = 1'b1
    } flush_state_e;

    // Ratio code ordering: auxiliary straps above interrupt pins
    function automatic logic [RATIO_W-1:0] make_ratio(input pin_bank_t p);
        return {p.aux, p.lint};
    endfunction

    // Build the strap record from the pins seen at the release edge
    function automatic strap_t decode_straps(input pin_bank_t p);
        strap_t s;
        s.bist       = ~p.init_n;
        s.float_outs = ~p.flush_n;
        s.ratio      = make_ratio(p);
        return s;
    endfunction

endpackage

// File: rtl/strap_pin_sync.sv
module strap_pin_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            chain[g] <= chain[g-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/strap_release_edge.sv
module strap_release_edge (
    input  logic clk,
    input  logic rst_sync_n,
    output logic rst_act,
    output logic rel_edge
);

    logic rst_prev_n;

    always_ff @(posedge clk) begin
        rst_prev_n <= rst_sync_n;
    end

    assign rst_act  = ~rst_sync_n;
    assign rel_edge = rst_sync_n & ~rst_prev_n;

endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_act,
    input  logic      rel_edge,
    input  pin_bank_t pins,
    output strap_t    straps
);

    strap_t straps_q;

    always_ff @(posedge clk) begin
        if (rst_act) begin
            straps_q <= STRAP_CLEAR;
        end else if (rel_edge) begin
            straps_q <= decode_straps(pins);
        end
    end

    assign straps = straps_q;

endmodule

// File: rtl/strap_cmd_decode.sv
module strap_cmd_decode (
    input  logic clk,
    input  logic rst_act,
    input  logic rel_edge,
    input  logic init_s_n,
    input  logic flush_s_n,
    input  logic flush_done,
    output logic soft_init,
    output logic flush_start,
    output logic flush_pending
);

    import strap_pkg::*;

    logic         init_prev_n;
    logic         flush_prev_n;
    logic         init_fall;
    logic         flush_fall;
    logic         run_ok;
    logic         soft_init_q;
    logic         flush_start_q;
    flush_state_e fstate;

    // Edge history follows the pins at all times, so a pin held low across
    // reset release never yields a late run-time edge
    always_ff @(posedge clk) begin
        init_prev_n  <= init_s_n;
        flush_prev_n <= flush_s_n;
    end

    assign init_fall  = init_prev_n & ~init_s_n;
    assign flush_fall = flush_prev_n & ~flush_s_n;
    assign run_ok     = ~rst_act & ~rel_edge;

    always_ff @(posedge clk) begin
        if (rst_act) begin
            soft_init_q <= 1'b0;
        end else begin
            soft_init_q <= init_fall & run_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_act) begin
            fstate        <= FL_IDLE;
            flush_start_q <= 1'b0;
        end else begin
            flush_start_q <= 1'b0;
            case (fstate)
                FL_IDLE: begin
                    if (flush_fall && run_ok) begin
                        fstate        <= FL_BUSY;
                        flush_start_q <= 1'b1;
                    end
                end
                FL_BUSY: begin
                    if (flush_done) begin
                        fstate <= FL_IDLE;
                    end
                end
                default: fstate <= FL_IDLE;
            endcase
        end
    end

    assign soft_init     = soft_init_q;
    assign flush_start   = flush_start_q;
    assign flush_pending = (fstate == FL_BUSY);

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
    import strap_pkg::*;
(
    input  logic               clk,
    input  logic               cpu_rst_n,
    input  logic               init_n,
    input  logic               flush_n,
    input  logic [LINT_W-1:0]  lint,
    input  logic [AUX_W-1:0]   aux_strap,
    input  logic               flush_done,
    output logic               soft_init,
    output logic               flush_start,
    output logic               flush_pending,
    output logic               bist_req,
    output logic               pins_float,
    output logic [RATIO_W-1:0] clk_ratio
);

    pin_bank_t raw_pins;
    pin_bank_t sync_pins;
    logic      rst_act;
    logic      rel_edge;
    strap_t    straps;

    assign raw_pins = '{rst_n: cpu_rst_n, init_n: init_n, flush_n: flush_n,
                        lint: lint, aux: aux_strap};

    strap_pin_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    strap_release_edge u_edge (
        .clk        (clk),
        .rst_sync_n (sync_pins.rst_n),
        .rst_act    (rst_act),
        .rel_edge   (rel_edge)
    );

    strap_capture u_cap (
        .clk      (clk),
        .rst_act  (rst_act),
        .rel_edge (rel_edge),
        .pins     (sync_pins),
        .straps   (straps)
    );

    strap_cmd_decode u_cmd (
        .clk           (clk),
        .rst_act       (rst_act),
        .rel_edge      (rel_edge),
        .init_s_n      (sync_pins.init_n),
        .flush_s_n     (sync_pins.flush_n),
        .flush_done    (flush_done),
        .soft_init     (soft_init),
        .flush_start   (flush_start),
        .flush_pending (flush_pending)
    );

    assign bist_req   = straps.bist;
    assign pins_float = straps.float_outs;
    assign clk_ratio  = straps.ratio;

endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk
    import strap_pkg::*;
(
    input logic               clk,
    input logic               rst_act,
    input logic               rel_edge,
    input logic               flush_done,
    input logic               soft_init,
    input logic               flush_start,
    input logic               flush_pending,
    input logic               bist_req,
    input logic               pins_float,
    input logic [RATIO_W-1:0] clk_ratio
);

    AST_SOFT_INIT_SINGLE: assert property (@(posedge clk) disable iff (rst_act)
        soft_init |=> !soft_init); // R5

    AST_START_MARKS_PENDING: assert property (@(posedge clk) disable iff (rst_act)
        flush_start |-> flush_pending); // R6

    AST_DONE_CLEARS_PENDING: assert property (@(posedge clk) disable iff (rst_act)
        (flush_pending && flush_done) |=> !flush_pending); // R6

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst_act)
        flush_pending |=> !flush_start); // R7

    AST_STRAPS_HOLD: assert property (@(posedge clk) disable iff (rst_act)
        !rel_edge |=> ($stable(clk_ratio) && $stable(bist_req) && $stable(pins_float))); // R4

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst_act)
        rel_edge |=> (!soft_init && !flush_start)); // R8

    AST_CLEARED_AT_RELEASE: assert property (@(posedge clk) disable iff (rst_act)
        rel_edge |-> (!bist_req && !pins_float && clk_ratio == '0 && !flush_pending)); // R9

endmodule

bind strap_sampler strap_sampler_chk u_chk (
    .clk           (clk),
    .rst_act       (rst_act),
    .rel_edge      (rel_edge),
    .flush_done    (flush_done),
    .soft_init     (soft_init),
    .flush_start   (flush_start),
    .flush_pending (flush_pending),
    .bist_req      (bist_req),
    .pins_float    (pins_float),
    .clk_ratio     (clk_ratio)
);

// File: tb/strap_sampler_test.sv
`timescale 1ns/1ps
module strap_sampler_test;

    logic       clk = 1'b0;
    logic       cpu_rst_n = 1'b0;
    logic       init_n = 1'b1;
    logic       flush_n = 1'b1;
    logic [1:0] lint = 2'b00;
    logic [1:0] aux_strap = 2'b00;
    logic       flush_done = 1'b0;
    logic       soft_init, flush_start, flush_pending, bist_req, pins_float;
    logic [3:0] clk_ratio;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    strap_sampler uut (
        .clk           (clk),
        .cpu_rst_n     (cpu_rst_n),
        .init_n        (init_n),
        .flush_n       (flush_n),
        .lint          (lint),
        .aux_strap     (aux_strap),
        .flush_done    (flush_done),
        .soft_init     (soft_init),
        .flush_start   (flush_start),
        .flush_pending (flush_pending),
        .bist_req      (bist_req),
        .pins_float    (pins_float),
        .clk_ratio     (clk_ratio)
    );

    // stim: {rst_n, init_n, flush_n, lint[1:0], aux[1:0], done}
    // exp : {soft_init, flush_start, flush_pending, bist_req, pins_float, clk_ratio[3:0]}
    localparam int NV = 13;
    localparam logic [7:0] STIM [NV] = '{
        8'b0_0_1_10_01_0,
        8'b1_0_1_10_01_0,
        8'b1_1_1_10_01_0,
        8'b1_0_1_10_01_0,
        8'b1_1_1_11_11_0,
        8'b1_1_0_11_11_0,
        8'b1_1_1_11_11_0,
        8'b1_1_0_11_11_0,
        8'b1_1_1_11_11_1,
        8'b1_1_0_11_11_0,
        8'b0_1_1_11_11_0,
        8'b1_1_0_01_10_0,
        8'b1_1_1_01_10_0
    };
    localparam logic [8:0] EXPV [NV] = '{
        9'b0_0_0_0_0_0000,
        9'b0_0_0_1_0_0110,
        9'b0_0_0_1_0_0110,
        9'b1_0_0_1_0_0110,
        9'b0_0_0_1_0_0110,
        9'b0_1_1_1_0_0110,
        9'b0_0_1_1_0_0110,
        9'b0_0_1_1_0_0110,
        9'b0_0_0_1_0_0110,
        9'b0_1_1_1_0_0110,
        9'b0_0_0_0_0_0000,
        9'b0_0_0_0_1_1001,
        9'b0_0_0_0_1_1001
    };

    function automatic string vtag(input int i);
        case (i)
            0:       return "R8 init edge during reset";
            1:       return "R2 R4 release with init low";
            2:       return "R5 rising init no pulse";
            3:       return "R5 init falling pulse";
            4:       return "R4 straps hold";
            5:       return "R6 flush start";
            6:       return "R6 pending holds";
            7:       return "R7 flush edge while pending";
            8:       return "R6 done clears";
            9:       return "R6 second flush";
            10:      return "R9 reset clears";
            11:      return "R3 R8 release with flush low";
            default: return "R3 float holds";
        endcase
    endfunction

    function automatic logic [8:0] outs();
        return {soft_init, flush_start, flush_pending, bist_req, pins_float, clk_ratio};
    endfunction

    task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] s);
        {cpu_rst_n, init_n, flush_n, lint, aux_strap, flush_done} = s;
    endtask

    task automatic step3();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        check("R9 reset state", outs(), 9'b0);

        for (int i = 0; i < NV; i++) begin
            apply(STIM[i]);
            step3();
            check(vtag(i), outs(), EXPV[i]);
        end

        // R6: done while idle has no effect
        flush_n = 1'b1;
        flush_done = 1'b1;
        step3();
        check("R6 done while idle", outs(), 9'b0_0_0_0_1_1001);
        flush_done = 1'b0;

        // R1 latency and R5 width
        init_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 not yet after two edges", outs(), 9'b0_0_0_0_1_1001);
        @(posedge clk);
        @(negedge clk);
        check("R1 pulse after third edge", outs(), 9'b1_0_0_0_1_1001);
        @(posedge clk);
        @(negedge clk);
        check("R5 pulse one cycle wide", outs(), 9'b0_0_0_0_1_1001);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule